// File: doc/BRIEF.md
# Pointer-expression address generator

This block turns the 9-bit memory operand of a table access into an effective address for a 512-word local table RAM. In the same cycle it can update one of two pointer registers. An immediate operand with bit 8 clear names a RAM word directly. With bit 8 set, the operand is a pointer expression. It picks pointer A or B, chooses pre- or post-modify addressing, and says whether the pointer moves by a signed index. A register-supplied operand can address the whole RAM. An optional 32-bit extended immediate replaces the 9-bit operand. It is a pointer expression with a wide signed offset only when its top nine bits hold one specific pattern.

Each access is a single-cycle strobe. The address and the RAM strobe are combinational from the inputs. The pointer write-back lands on the clock edge that ends the access, so the access takes no extra cycle. A small RAM model is included so that the whole path can be checked. It returns read data one cycle after the strobe, together with a done pulse. Software-style direct loads of either pointer come in through their own ports.

Top module: `ptr_addr_gen`

## Requirements
- R1: When op_imm=1, ext_valid=0 and operand[8]=0, the effective address is operand itself, which lies in 0x000..0x0FF. operand[8]=0 never reaches the upper half of the RAM.
- R2: When op_imm=0, the effective address is reg_addr, over the full range 0x000..0x1FF. operand and the extended immediate are then ignored, and the pointers are unchanged.
- R3: When op_imm=1, ext_valid=0 and operand[8]=1, the operand fields are as follows. operand[7] selects the pointer (0 = pointer A, 1 = pointer B). operand[6] is the update flag (1 = update). operand[5] is the post-modify flag. operand[4:0] is a two's-complement index from -16 to +15.
- R4: With the post-modify flag clear, the address is pointer + index. With it set, the address is the unmodified pointer. When the update flag is 1, the selected pointer becomes pointer + index. The other pointer is unchanged, and both are unchanged when the update flag is 0.
- R5: All pointer and address arithmetic wraps modulo 512.
- R6: With parameter WIDE_IDX=1, a non-updating expression (operand[6]=0) always uses pre-modify addressing. Its index is then operand[5:0], a signed value from -32 to +31. Updating expressions keep the 5-bit index and the post-modify flag of R3. WIDE_IDX=0 behaves as R3 for all expressions.
- R7: An updated pointer value is visible on ptra/ptrb in the cycle right after the strobe. done is high in exactly the cycle after each start, and a read's data appears on rd_data in that same cycle.
- R8: With op_imm=1 and ext_valid=1, ext_imm is a pointer expression only when ext_imm[31:23] = 9'b000000001. In that case ext_imm[22] selects the pointer, ext_imm[21] is the update flag and ext_imm[20] is the post-modify flag. ext_imm[19:0] is a signed offset, applied modulo 512.
- R9: With op_imm=1 and ext_valid=1 and any other top-nine-bit value, ext_imm[8:0] is a plain address over the full range, and the pointers are unchanged.
- R10: Reset clears both pointers to zero and holds done low.
- R11: A direct pointer load (ptra_we/ptrb_we) in the same cycle as an expression update of that pointer wins. The pointer takes the load value.
- R12: A write access (start with is_wr=1) stores wr_data at the effective address. A later read of that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle access strobe |
| is_wr | input | 1 | 1 = write access, 0 = read access |
| op_imm | input | 1 | 1 = operand is an immediate, 0 = use reg_addr |
| operand | input | 9 | Immediate operand |
| reg_addr | input | 9 | Register-supplied address |
| ext_valid | input | 1 | Extended immediate replaces operand |
| ext_imm | input | 32 | Extended immediate value |
| wr_data | input | 32 | Write data |
| ptra_we | input | 1 | Direct load of pointer A |
| ptra_wdata | input | 9 | Pointer A load value |
| ptrb_we | input | 1 | Direct load of pointer B |
| ptrb_wdata | input | 9 | Pointer B load value |
| eff_addr | output | 9 | Effective RAM address |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| rd_data | output | 32 | Read data, valid with done |
| done | output | 1 | Pulses one cycle after start |
| ptra | output | 9 | Pointer A |
| ptrb | output | 9 | Pointer B |

## Verification
Several properties are checked on every cycle:
- a direct immediate never addresses the upper half of the RAM;
- done follows each strobe by exactly one cycle;
- a direct pointer load always wins;
- pointers hold still when nothing updates them.

The arithmetic is shown only by the bench. Its sweeps cover every 9-bit immediate in both index modes and compare the address and pointer values against a model computed from the field layout. The bench also covers:
- pointer walks across the 0x1FF/0x000 wrap;
- the extended-immediate pattern match and its negative offsets;
- full-range register addressing;
- read-back through the RAM model.

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen #(
  parameter int AW = 9,
  parameter int DW = 32,
  parameter bit WIDE_IDX = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_wr,
  input  logic          op_imm,
  input  logic [AW-1:0] operand,
  input  logic [AW-1:0] reg_addr,
  input  logic          ext_valid,
  input  logic [31:0]   ext_imm,
  input  logic [DW-1:0] wr_data,
  input  logic          ptra_we,
  input  logic [AW-1:0] ptra_wdata,
  input  logic          ptrb_we,
  input  logic [AW-1:0] ptrb_wdata,
  output logic [AW-1:0] eff_addr,
  output logic          ram_rd,
  output logic          ram_wr,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic [AW-1:0] ptra,
  output logic [AW-1:0] ptrb
);
  localparam int DEPTH = 1 << AW;

  logic          use_ext, ext_ptr, imm_ptr, is_ptr;
  logic          sel, upd, post;
  logic [AW-1:0] idx, base, sum, direct;
  logic          unused_bits;

  assign use_ext = op_imm && ext_valid;
  assign ext_ptr = use_ext && (ext_imm[31:23] == 9'b000000001);
  assign imm_ptr = op_imm && !ext_valid && operand[8];
  assign is_ptr  = ext_ptr || imm_ptr;
  assign unused_bits = ^ext_imm[19:AW];

  always_comb begin
    if (ext_ptr) begin
      sel  = ext_imm[22];
      upd  = ext_imm[21];
      post = ext_imm[20];
      idx  = ext_imm[AW-1:0];
    end else begin
      sel = operand[7];
      upd = operand[6];
      if (WIDE_IDX && !operand[6]) begin
        post = 1'b0;
        idx  = {{(AW-6){operand[5]}}, operand[5:0]};
      end else begin
        post = operand[5];
        idx  = {{(AW-5){operand[4]}}, operand[4:0]};
      end
    end
  end

  assign base   = sel ? ptrb : ptra;
  assign sum    = base + idx;
  assign direct = !op_imm ? reg_addr : (ext_valid ? ext_imm[AW-1:0] : operand);

  assign eff_addr = is_ptr ? (post ? base : sum) : direct;
  assign ram_rd   = start && !is_wr;
  assign ram_wr   = start && is_wr;

  wire upd_a = start && is_ptr && upd && !sel;
  wire upd_b = start && is_ptr && upd && sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptra <= '0;
      ptrb <= '0;
      done <= 1'b0;
    end else begin
      done <= start;
      if (ptra_we)    ptra <= ptra_wdata;
      else if (upd_a) ptra <= sum;
      if (ptrb_we)    ptrb <= ptrb_wdata;
      else if (upd_b) ptrb <= sum;
    end
  end

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ram_wr) mem[eff_addr] <= wr_data;
    if (ram_rd) rd_data <= mem[eff_addr];
  end

  // R1
  direct_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_imm && !ext_valid && !operand[8]) |-> (eff_addr[AW-1] == 1'b0));

  // R7
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  // R7
  no_stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  // R11
  ptra_load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptra_we |=> (ptra == $past(ptra_wdata)));

  // R11
  ptrb_load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptrb_we |=> (ptrb == $past(ptrb_wdata)));

  // R2
  reg_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !op_imm && !ptra_we && !ptrb_we) |=> ($stable(ptra) && $stable(ptrb)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !ptra_we && !ptrb_we) |=> ($stable(ptra) && $stable(ptrb)));

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_rd && ram_wr));
endmodule

// File: tb/ptr_addr_gen_test.sv
module ptr_addr_gen_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, start, is_wr, op_imm, ext_valid, ptra_we, ptrb_we;
  logic [8:0]  operand, reg_addr, ptra_wdata, ptrb_wdata;
  logic [31:0] ext_imm, wr_data;
  logic [8:0]  ea0, ea1, pa0, pa1, pb0, pb1;
  logic        rd0, rd1, wr0, wr1, dn0, dn1;
  logic [31:0] q0, q1;

  int total = 0, bad = 0;
  bit finished = 0;

  ptr_addr_gen #(.WIDE_IDX(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_wr(is_wr), .op_imm(op_imm),
    .operand(operand), .reg_addr(reg_addr), .ext_valid(ext_valid), .ext_imm(ext_imm),
    .wr_data(wr_data), .ptra_we(ptra_we), .ptra_wdata(ptra_wdata), .ptrb_we(ptrb_we),
    .ptrb_wdata(ptrb_wdata), .eff_addr(ea0), .ram_rd(rd0), .ram_wr(wr0),
    .rd_data(q0), .done(dn0), .ptra(pa0), .ptrb(pb0));

  ptr_addr_gen #(.WIDE_IDX(1'b1)) uut_w (
    .clk(clk), .rst_n(rst_n), .start(start), .is_wr(is_wr), .op_imm(op_imm),
    .operand(operand), .reg_addr(reg_addr), .ext_valid(ext_valid), .ext_imm(ext_imm),
    .wr_data(wr_data), .ptra_we(ptra_we), .ptra_wdata(ptra_wdata), .ptrb_we(ptrb_we),
    .ptrb_wdata(ptrb_wdata), .eff_addr(ea1), .ram_rd(rd1), .ram_wr(wr1),
    .rd_data(q1), .done(dn1), .ptra(pa1), .ptrb(pb1));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [26:0] model(input bit wide, input logic [8:0] op,
                                        input logic [8:0] pa, input logic [8:0] pb);
    logic s, u, p;
    logic [8:0] idx, base, sum, eff, na, nb;
    s = op[7];
    u = op[6];
    if (wide && !u) begin
      p = 1'b0;
      idx = {{3{op[5]}}, op[5:0]};
    end else begin
      p = op[5];
      idx = {{4{op[4]}}, op[4:0]};
    end
    base = s ? pb : pa;
    sum = base + idx;
    eff = op[8] ? (p ? base : sum) : op;
    na = pa;
    nb = pb;
    if (op[8] && u) begin
      if (s) nb = sum;
      else   na = sum;
    end
    return {eff, na, nb};
  endfunction

  task automatic idle();
    start = 0; is_wr = 0; op_imm = 1; ext_valid = 0; ptra_we = 0; ptrb_we = 0;
  endtask

  task automatic load_ptrs(input logic [8:0] a, input logic [8:0] b);
    @(negedge clk);
    idle();
    ptra_we = 1; ptra_wdata = a; ptrb_we = 1; ptrb_wdata = b;
    @(negedge clk);
    idle();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #600000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [26:0] m0, m1;
    logic [8:0] a, b;
    rst_n = 0; idle(); operand = 0; reg_addr = 0; ext_imm = 0; wr_data = 0;
    ptra_wdata = 0; ptrb_wdata = 0;
    #9;
    // R10
    check("R10 ptra reset", {23'd0, pa0}, 0);
    check("R10 ptrb reset", {23'd0, pb0}, 0);
    check("R10 done reset", {31'd0, dn0}, 0);
    @(negedge clk);
    rst_n = 1;

    // R1 R3 R4 R5 R6 R7: sweep every immediate in both index modes
    for (int op = 0; op < 512; op++) begin
      a = 9'(op * 7 + 500);
      b = 9'(op * 13 + 256);
      load_ptrs(a, b);
      m0 = model(1'b0, 9'(op), a, b);
      m1 = model(1'b1, 9'(op), a, b);
      start = 1; operand = 9'(op);
      #1;
      check(op[8] ? "R3 R4 R5 eff" : "R1 eff", {23'd0, ea0}, {23'd0, m0[26:18]});
      check("R6 wide eff", {23'd0, ea1}, {23'd0, m1[26:18]});
      @(negedge clk);
      idle();
      check("R4 R7 ptra", {23'd0, pa0}, {23'd0, m0[17:9]});
      check("R4 R7 ptrb", {23'd0, pb0}, {23'd0, m0[8:0]});
      check("R6 ptra", {23'd0, pa1}, {23'd0, m1[17:9]});
      check("R6 ptrb", {23'd0, pb1}, {23'd0, m1[8:0]});
      check("R7 done", {31'd0, dn0}, 1);
    end

    // R12 R2: fill every word through register addresses
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      idle();
      start = 1; is_wr = 1; op_imm = 0; reg_addr = 9'(i); operand = 9'h1FF;
      wr_data = 32'hA5000000 ^ (i * 32'h10001);
      #1;
      check("R2 reg eff", {23'd0, ea0}, i);
    end
    @(negedge clk);
    idle();
    check("R2 ptra unchanged", {23'd0, pa0}, {23'd0, 9'(511 * 7 + 500)});

    // R5 R7 R12: post-increment walk of pointer A across the top of the RAM
    load_ptrs(9'h1F0, 9'h000);
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      start = 1; op_imm = 1; operand = 9'b1_0_1_1_00001;
      #1;
      check("R4 post eff", {23'd0, ea0}, {23'd0, 9'(9'h1F0 + k)});
      @(negedge clk);
      idle();
      check("R7 R12 rd_data", q0, 32'hA5000000 ^ ({23'd0, 9'(9'h1F0 + k)} * 32'h10001));
      check("R7 rd done", {31'd0, dn0}, 1);
      check("R5 ptra wrap", {23'd0, pa0}, {23'd0, 9'(9'h1F1 + k)});
    end

    // R8: pointer B pre-modify update with offset -3
    load_ptrs(9'h010, 9'h005);
    start = 1; ext_valid = 1; ext_imm = {9'b000000001, 3'b110, 20'hFFFFD};
    #1;
    check("R8 ext eff", {23'd0, ea0}, 9'h002);
    @(negedge clk);
    idle();
    check("R8 ext ptrb", {23'd0, pb0}, 9'h002);
    check("R8 ext ptra", {23'd0, pa0}, 9'h010);

    // R8: pointer A post-modify with large offset +0x300 (mod 512 = +0x100)
    @(negedge clk);
    start = 1; ext_valid = 1; ext_imm = {9'b000000001, 3'b011, 20'h00300};
    #1;
    check("R8 ext post eff", {23'd0, ea0}, 9'h010);
    @(negedge clk);
    idle();
    check("R8 ext post ptra", {23'd0, pa0}, 9'h110);

    // R9: other patterns are plain full-range addresses
    @(negedge clk);
    start = 1; ext_valid = 1; ext_imm = {9'b000000011, 3'b111, 11'd0, 9'h1AB};
    #1;
    check("R9 plain eff", {23'd0, ea0}, 9'h1AB);
    @(negedge clk);
    idle();
    check("R9 ptra kept", {23'd0, pa0}, 9'h110);
    check("R9 ptrb kept", {23'd0, pb0}, 9'h002);
    @(negedge clk);
    start = 1; ext_valid = 1; ext_imm = {9'b000000000, 3'b111, 11'd0, 9'h1FE};
    #1;
    check("R9 plain eff 2", {23'd0, ea0}, 9'h1FE);
    @(negedge clk);
    idle();
    check("R9 ptra kept 2", {23'd0, pa0}, 9'h110);

    // R11: direct load beats same-cycle expression update
    load_ptrs(9'h020, 9'h040);
    start = 1; operand = 9'b1_0_1_0_00100; ptra_we = 1; ptra_wdata = 9'h155;
    @(negedge clk);
    idle();
    check("R11 ptra load wins", {23'd0, pa0}, 9'h155);
    start = 1; operand = 9'b1_1_1_0_11111; ptrb_we = 1; ptrb_wdata = 9'h0AA;
    @(negedge clk);
    idle();
    check("R11 ptrb load wins", {23'd0, pb0}, 9'h0AA);
    @(negedge clk);
    check("R7 done drops", {31'd0, dn0}, 0);

    summary();
  end
endmodule